// File: doc/BRIEF.md
# Frame-Linear Video Timing Generator

This block is a display timing engine clocked by the pixel clock. Software programs a small set of timing registers through a single-cycle write port. The engine then produces horizontal sync, vertical sync, a data-enable and a pixel-request strobe. On its pixel output it forwards incoming pixel data, or a fill colour when the display window is closed or the pixel source has nothing valid. It also maintains a line counter and a frame counter, both visible on output ports.

Vertical timing does not use a line counter. It is measured on one frame-linear position counter that runs from 0 to the programmed frame period minus one, so every vertical limit is an absolute pixel-clock count within the frame. All timing registers are double-buffered. Writes go to a shadow set, and the shadow set is copied into the working set only when a frame begins. A mode change made in the middle of a frame therefore cannot tear that frame.

The engine is a three-state machine, and the transitions below are the only ones it takes:
- IDLE goes to RUN ("start") when the run bit is set.
- RUN goes to STOPPING ("stop request") when the run bit is cleared away from the frame's last position.
- RUN goes straight to IDLE ("stop at wrap") when the run bit is cleared on the last position.
- STOPPING goes back to RUN ("resume") if the run bit is set again.
- STOPPING goes to IDLE ("drain") at the frame's last position.

Top module: `frame_timing_gen`

## Requirements
- R1: The horizontal position counts from 0 to htotal−1 and wraps. htotal is bits [HCW-1:0] of address 0, and the pulse width is bits [16+HCW-1:16] of the same address. Hsync is in its active state while the horizontal position is below the pulse width.
- R2: The frame position counts from 0 to vper−1 and then wraps to 0. vper is written at address 1. The horizontal position also restarts at that wrap. Vsync is in its active state while the frame position is below the vsync length, which is written at address 2.
- R3: de and pix_req are high only when both of these hold:
  - the horizontal position lies in [hstart, hend], where hstart is bits [15:0] and hend is bits [31:16] of address 3;
  - the frame position lies in [vstart+skew, vend+skew], where vstart is at address 4 and vend is at address 5.
- R4: pix_out takes one of three values:
  - pix_in when de and pix_valid are both high;
  - the underflow colour when de is high and pix_valid is low (address 7, bits [16+CW-1:16]);
  - the border colour when de is low (address 7, bits [CW-1:0]).
- R5: At address 8, bit 0 makes hsync active-low and bit 1 makes vsync active-low. While the engine is idle, both syncs sit at their inactive level.
- R6: The skew value at address 6 is added, modulo 2^PCW, to both vertical window limits.
- R7: Every register except the run bit and the counter enables is shadowed. A write takes effect at the next frame start and never within the current frame.
- R8: The run bit is bit 0 of address 10. Setting it in IDLE makes position 0 appear in the cycle after the edge that follows the write. Clearing it lets the current frame finish, after which the engine goes idle with de low.
- R9: At address 9, bit 0 enables the frame counter, which steps once at each frame wrap. Bit 1 enables the line counter, which clears at each frame wrap and steps at each horizontal wrap. A disabled counter holds its value.
- R10: After reset, the following hold:
  - the engine is idle;
  - all outputs are inactive and high-active;
  - both counters are zero;
  - the border colour is 0 and the underflow colour is all ones (0xFF for CW=8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address |
| cfg_wdata | input | DW | Register write data |
| pix_in | input | CW | Incoming pixel |
| pix_valid | input | 1 | pix_in holds a valid pixel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_req | output | 1 | Pixel request strobe |
| pix_out | output | CW | Pixel or fill colour |
| line_cnt | output | LCW | Line counter |
| frame_cnt | output | FCW | Frame counter |

## Verification
The sync, data-enable and pixel outputs are combinational from the position counters and from pix_in and pix_valid. Their value for a position is therefore due in the same cycle as that position. A run-bit write takes one edge to land and one more to start the engine, so position 0 is due in the second cycle after the write's edge. Shadowed writes must show their effect exactly on the first position of the following frame.

The driver pushes one expected item per cycle, computed from the programmed mode. It drives pix_valid and pix_in for each item just after the rising edge. The monitor pops and compares one item on every falling edge, so each comparison falls in the exact cycle its result is due.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUN      = 2'd1,
        ST_STOPPING = 2'd2
    } ftg_state_e;

    localparam logic [3:0] ADDR_HTIME  = 4'd0;
    localparam logic [3:0] ADDR_VPER   = 4'd1;
    localparam logic [3:0] ADDR_VLEN   = 4'd2;
    localparam logic [3:0] ADDR_HWIN   = 4'd3;
    localparam logic [3:0] ADDR_VSTART = 4'd4;
    localparam logic [3:0] ADDR_VEND   = 4'd5;
    localparam logic [3:0] ADDR_SKEW   = 4'd6;
    localparam logic [3:0] ADDR_COLOR  = 4'd7;
    localparam logic [3:0] ADDR_POL    = 4'd8;
    localparam logic [3:0] ADDR_CNTEN  = 4'd9;
    localparam logic [3:0] ADDR_RUN    = 4'd10;

endpackage

// File: rtl/ftg_regs.sv
module ftg_regs
    import ftg_pkg::*;
#(
    parameter int HCW = 12,
    parameter int PCW = 24,
    parameter int CW  = 8,
    parameter int AW  = 4,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic           load,
    output logic [HCW-1:0] a_htot,
    output logic [HCW-1:0] a_hpw,
    output logic [HCW-1:0] a_hst,
    output logic [HCW-1:0] a_hend,
    output logic [PCW-1:0] a_vper,
    output logic [PCW-1:0] a_vlen,
    output logic [PCW-1:0] a_vst,
    output logic [PCW-1:0] a_vend,
    output logic [PCW-1:0] a_skew,
    output logic [CW-1:0]  a_border,
    output logic [CW-1:0]  a_under,
    output logic           a_pol_h,
    output logic           a_pol_v,
    output logic [1:0]     cnt_en,
    output logic           run_req
);
    localparam int HI = 16;

    logic [HCW-1:0] s_htot, s_hpw, s_hst, s_hend;
    logic [PCW-1:0] s_vper, s_vlen, s_vst, s_vend, s_skew;
    logic [CW-1:0]  s_border, s_under;
    logic           s_pol_h, s_pol_v;
    logic           unused_wdata;

    assign unused_wdata = ^wdata;

    // shadow set, written by software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_htot   <= '0;
            s_hpw    <= '0;
            s_hst    <= '0;
            s_hend   <= '0;
            s_vper   <= '0;
            s_vlen   <= '0;
            s_vst    <= '0;
            s_vend   <= '0;
            s_skew   <= '0;
            s_border <= '0;
            s_under  <= '1;
            s_pol_h  <= 1'b0;
            s_pol_v  <= 1'b0;
            cnt_en   <= 2'b00;
            run_req  <= 1'b0;
        end else if (we) begin
            case (addr)
                ADDR_HTIME: begin
                    s_htot <= wdata[HCW-1:0];
                    s_hpw  <= wdata[HI +: HCW];
                end
                ADDR_VPER:   s_vper <= wdata[PCW-1:0];
                ADDR_VLEN:   s_vlen <= wdata[PCW-1:0];
                ADDR_HWIN: begin
                    s_hst  <= wdata[HCW-1:0];
                    s_hend <= wdata[HI +: HCW];
                end
                ADDR_VSTART: s_vst  <= wdata[PCW-1:0];
                ADDR_VEND:   s_vend <= wdata[PCW-1:0];
                ADDR_SKEW:   s_skew <= wdata[PCW-1:0];
                ADDR_COLOR: begin
                    s_border <= wdata[CW-1:0];
                    s_under  <= wdata[HI +: CW];
                end
                ADDR_POL: begin
                    s_pol_h <= wdata[0];
                    s_pol_v <= wdata[1];
                end
                ADDR_CNTEN:  cnt_en  <= wdata[1:0];
                ADDR_RUN:    run_req <= wdata[0];
                default: ;
            endcase
        end
    end

    // working set, copied at frame start only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_htot   <= '0;
            a_hpw    <= '0;
            a_hst    <= '0;
            a_hend   <= '0;
            a_vper   <= '0;
            a_vlen   <= '0;
            a_vst    <= '0;
            a_vend   <= '0;
            a_skew   <= '0;
            a_border <= '0;
            a_under  <= '1;
            a_pol_h  <= 1'b0;
            a_pol_v  <= 1'b0;
        end else if (load) begin
            a_htot   <= s_htot;
            a_hpw    <= s_hpw;
            a_hst    <= s_hst;
            a_hend   <= s_hend;
            a_vper   <= s_vper;
            a_vlen   <= s_vlen;
            a_vst    <= s_vst;
            a_vend   <= s_vend;
            a_skew   <= s_skew;
            a_border <= s_border;
            a_under  <= s_under;
            a_pol_h  <= s_pol_h;
            a_pol_v  <= s_pol_v;
        end
    end

endmodule

// File: rtl/ftg_ctrl.sv
module ftg_ctrl
    import ftg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_req,
    input  logic       at_wrap,
    output ftg_state_e state,
    output logic       running,
    output logic       load
);
    ftg_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     nxt = run_req ? ST_RUN : ST_IDLE;
            ST_RUN: begin
                if (!run_req) nxt = at_wrap ? ST_IDLE : ST_STOPPING;
            end
            ST_STOPPING: begin
                if (run_req)      nxt = ST_RUN;
                else if (at_wrap) nxt = ST_IDLE;
            end
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        running = (state != ST_IDLE);
        load    = (state == ST_IDLE) ? run_req : at_wrap;
    end

endmodule

// File: rtl/ftg_counters.sv
module ftg_counters #(
    parameter int HCW = 12,
    parameter int PCW = 24,
    parameter int LCW = 12,
    parameter int FCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           running,
    input  logic [HCW-1:0] htot,
    input  logic [PCW-1:0] vper,
    input  logic [1:0]     cnt_en,
    output logic [PCW-1:0] pos,
    output logic [HCW-1:0] hpos,
    output logic [LCW-1:0] line,
    output logic [FCW-1:0] frame,
    output logic           at_wrap
);
    logic [PCW-1:0] p_last;
    logic [HCW-1:0] h_last_v;
    logic           h_last;

    assign p_last   = vper - PCW'(1);
    assign h_last_v = htot - HCW'(1);
    assign at_wrap  = running && (pos == p_last);
    assign h_last   = (hpos == h_last_v);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos  <= '0;
            hpos <= '0;
        end else if (!running) begin
            pos  <= '0;
            hpos <= '0;
        end else begin
            pos  <= at_wrap ? '0 : pos + PCW'(1);
            hpos <= (at_wrap || h_last) ? '0 : hpos + HCW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line <= '0;
        end else if (running && cnt_en[1]) begin
            if (at_wrap)     line <= '0;
            else if (h_last) line <= line + LCW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    frame <= '0;
        else if (at_wrap && cnt_en[0]) frame <= frame + FCW'(1);
    end

endmodule

// File: rtl/ftg_pixel.sv
module ftg_pixel #(
    parameter int HCW = 12,
    parameter int PCW = 24,
    parameter int CW  = 8
) (
    input  logic           running,
    input  logic [PCW-1:0] pos,
    input  logic [HCW-1:0] hpos,
    input  logic [HCW-1:0] hpw,
    input  logic [HCW-1:0] hst,
    input  logic [HCW-1:0] hend,
    input  logic [PCW-1:0] vlen,
    input  logic [PCW-1:0] vst,
    input  logic [PCW-1:0] vend,
    input  logic [PCW-1:0] skew,
    input  logic [CW-1:0]  border,
    input  logic [CW-1:0]  under,
    input  logic           pol_h,
    input  logic           pol_v,
    input  logic [CW-1:0]  pix_in,
    input  logic           pix_valid,
    output logic           hsync,
    output logic           vsync,
    output logic           de,
    output logic           pix_req,
    output logic [CW-1:0]  pix_out
);
    logic [PCW-1:0] v_lo, v_hi;
    logic           hs_on, vs_on, h_in, v_in;

    always_comb begin
        v_lo    = vst + skew;
        v_hi    = vend + skew;
        hs_on   = running && (hpos < hpw);
        vs_on   = running && (pos < vlen);
        h_in    = (hpos >= hst) && (hpos <= hend);
        v_in    = (pos >= v_lo) && (pos <= v_hi);
        de      = running && h_in && v_in;
        pix_req = de;
        hsync   = hs_on ^ pol_h;
        vsync   = vs_on ^ pol_v;
        if (!de)            pix_out = border;
        else if (pix_valid) pix_out = pix_in;
        else                pix_out = under;
    end

endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen
    import ftg_pkg::*;
#(
    parameter int HCW = 12,
    parameter int PCW = 24,
    parameter int LCW = 12,
    parameter int FCW = 16,
    parameter int CW  = 8,
    parameter int AW  = 4,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    input  logic [CW-1:0]  pix_in,
    input  logic           pix_valid,
    output logic           hsync,
    output logic           vsync,
    output logic           de,
    output logic           pix_req,
    output logic [CW-1:0]  pix_out,
    output logic [LCW-1:0] line_cnt,
    output logic [FCW-1:0] frame_cnt
);
    logic [HCW-1:0] a_htot, a_hpw, a_hst, a_hend;
    logic [PCW-1:0] a_vper, a_vlen, a_vst, a_vend, a_skew;
    logic [CW-1:0]  a_border, a_under;
    logic           a_pol_h, a_pol_v;
    logic [1:0]     cnt_en;
    logic           run_req;
    ftg_state_e     state;
    logic           running, load, at_wrap;
    logic [PCW-1:0] pos_q;
    logic [HCW-1:0] hpos_q;

    ftg_regs #(.HCW(HCW), .PCW(PCW), .CW(CW), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .load(load),
        .a_htot(a_htot), .a_hpw(a_hpw), .a_hst(a_hst), .a_hend(a_hend),
        .a_vper(a_vper), .a_vlen(a_vlen), .a_vst(a_vst), .a_vend(a_vend),
        .a_skew(a_skew), .a_border(a_border), .a_under(a_under),
        .a_pol_h(a_pol_h), .a_pol_v(a_pol_v), .cnt_en(cnt_en), .run_req(run_req)
    );

    ftg_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .at_wrap(at_wrap),
        .state(state), .running(running), .load(load)
    );

    ftg_counters #(.HCW(HCW), .PCW(PCW), .LCW(LCW), .FCW(FCW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .running(running), .htot(a_htot), .vper(a_vper),
        .cnt_en(cnt_en), .pos(pos_q), .hpos(hpos_q), .line(line_cnt),
        .frame(frame_cnt), .at_wrap(at_wrap)
    );

    ftg_pixel #(.HCW(HCW), .PCW(PCW), .CW(CW)) u_pix (
        .running(running), .pos(pos_q), .hpos(hpos_q), .hpw(a_hpw), .hst(a_hst),
        .hend(a_hend), .vlen(a_vlen), .vst(a_vst), .vend(a_vend), .skew(a_skew),
        .border(a_border), .under(a_under), .pol_h(a_pol_h), .pol_v(a_pol_v),
        .pix_in(pix_in), .pix_valid(pix_valid), .hsync(hsync), .vsync(vsync),
        .de(de), .pix_req(pix_req), .pix_out(pix_out)
    );

endmodule

// File: rtl/ftg_checker.sv
module ftg_checker
    import ftg_pkg::*;
#(
    parameter int HCW = 12,
    parameter int PCW = 24,
    parameter int LCW = 12,
    parameter int FCW = 16
) (
    input logic           clk,
    input logic           rst_n,
    input ftg_state_e     state,
    input logic           running,
    input logic           at_wrap,
    input logic [PCW-1:0] pos,
    input logic [HCW-1:0] hpos,
    input logic [PCW-1:0] vper,
    input logic           de,
    input logic [1:0]     cnt_en,
    input logic [LCW-1:0] line,
    input logic [FCW-1:0] frame
);
    // R2: the frame position never reaches the programmed period
    a_r2_pos_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (pos < vper));

    // R1: horizontal position advances by one between restarts
    a_r1_hpos_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && hpos != '0) |-> (hpos == HCW'($past(hpos) + HCW'(1))));

    // R8: the engine leaves its active states only from the frame's last position
    a_r8_stop_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !at_wrap) |=> (state != ST_IDLE));

    // R8: an idle engine shows no data-enable and sits at position 0
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!de && pos == '0));

    // R9: the line counter restarts after a frame wrap when enabled
    a_r9_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (at_wrap && cnt_en[1]) |=> (line == '0));

    // R9: the frame counter only moves on a wrap
    a_r9_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !at_wrap |=> $stable(frame));

endmodule

bind frame_timing_gen ftg_checker #(.HCW(HCW), .PCW(PCW), .LCW(LCW), .FCW(FCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .running(running), .at_wrap(at_wrap),
    .pos(pos_q), .hpos(hpos_q), .vper(a_vper), .de(de), .cnt_en(cnt_en),
    .line(line_cnt), .frame(frame_cnt)
);

// File: tb/frame_timing_gen_tb.sv
module frame_timing_gen_tb;
    import ftg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  pix_in = '0;
    logic        pix_valid = 1'b0;
    logic        hsync, vsync, de, pix_req;
    logic [7:0]  pix_out;
    logic [11:0] line_cnt;
    logic [15:0] frame_cnt;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    frame_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_in(pix_in), .pix_valid(pix_valid),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_req(pix_req),
        .pix_out(pix_out), .line_cnt(line_cnt), .frame_cnt(frame_cnt)
    );

    typedef struct {
        logic       hs, vs, de, valid;
        logic [7:0] pix, din;
        int         line, frame;
        string      tag;
    } exp_t;

    exp_t q[$];

    // bench copy of the programmed mode
    int m_htot, m_hpw, m_vper, m_vlen, m_hst, m_hend, m_vst, m_vend, m_skew;
    int m_border, m_under;
    bit m_polh, m_polv, m_fen;
    int fexp = 0;

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push_frame(input bit valid, input string tag);
        for (int p = 0; p < m_vper; p++) begin
            exp_t e;
            int h;
            h = p % m_htot;
            e.valid = valid;
            e.din   = 8'(p) ^ 8'hA5;
            e.hs    = (h < m_hpw) ^ m_polh;
            e.vs    = (p < m_vlen) ^ m_polv;
            e.de    = (h >= m_hst) && (h <= m_hend) &&
                      (p >= m_vst + m_skew) && (p <= m_vend + m_skew);
            e.pix   = e.de ? (valid ? e.din : 8'(m_under)) : 8'(m_border);
            e.line  = p / m_htot;
            e.frame = fexp;
            e.tag   = tag;
            q.push_back(e);
        end
        if (m_fen) fexp++;
    endtask

    task automatic push_idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.valid = 1'b0; e.din = 8'h00;
            e.hs = m_polh; e.vs = m_polv; e.de = 1'b0;
            e.pix = 8'(m_border); e.line = 0; e.frame = fexp; e.tag = tag;
            q.push_back(e);
        end
    endtask

    task automatic check1(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp_v);
        end
    endtask

    // drive pixel source for the item due in this cycle
    always @(posedge clk) begin
        #1;
        if (q.size() != 0) begin
            pix_valid = q[0].valid;
            pix_in    = q[0].din;
        end else begin
            pix_valid = 1'b0;
        end
    end

    // monitor: one item per cycle, compared away from the rising edge
    always @(negedge clk) begin
        if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (hsync !== e.hs || vsync !== e.vs || de !== e.de || pix_req !== e.de ||
                pix_out !== e.pix || line_cnt !== 12'(e.line) || frame_cnt !== 16'(e.frame)) begin
                n_err++;
                $display("FAIL %s act hs=%b vs=%b de=%b req=%b pix=%h line=%0d frame=%0d exp hs=%b vs=%b de=%b pix=%h line=%0d frame=%0d",
                         e.tag, hsync, vsync, de, pix_req, pix_out, line_cnt, frame_cnt,
                         e.hs, e.vs, e.de, e.pix, e.line, e.frame);
            end
        end
    end

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check1("R10 hsync", 32'(hsync), 0);
        check1("R10 vsync", 32'(vsync), 0);
        check1("R10 de", 32'(de), 0);
        check1("R10 pix_req", 32'(pix_req), 0);
        check1("R10 pix_out", 32'(pix_out), 0);
        check1("R10 line_cnt", 32'(line_cnt), 0);
        check1("R10 frame_cnt", 32'(frame_cnt), 0);

        m_htot = 8; m_hpw = 2; m_vper = 48; m_vlen = 16;
        m_hst = 3; m_hend = 6; m_vst = 20; m_vend = 39; m_skew = 0;
        m_border = 8'h00; m_under = 8'hFF; m_polh = 0; m_polv = 0; m_fen = 1;
        wr(ADDR_HTIME, 32'h0002_0008);
        wr(ADDR_VPER, 32'd48);
        wr(ADDR_VLEN, 32'd16);
        wr(ADDR_HWIN, 32'h0006_0003);
        wr(ADDR_VSTART, 32'd20);
        wr(ADDR_VEND, 32'd39);
        wr(ADDR_CNTEN, 32'd3);
        // R8: start, position 0 due two edges after the write edge
        wr(ADDR_RUN, 32'd1);
        #1;
        push_frame(1'b1, "R1 R2 R3 R4 R8 R9 frame1");
        // R10/R4: default underflow colour with no valid pixels; R7 old values still apply
        push_frame(1'b0, "R4 R10 R7 frame2");
        m_hpw = 3; m_skew = 8; m_border = 8'h11; m_under = 8'h22; m_polh = 1; m_polv = 1;
        // R5 R6 R7: new values from the next frame start
        push_frame(1'b0, "R5 R6 R7 frame3");
        push_frame(1'b1, "R3 R4 R5 R6 frame4");
        // R8: stop takes effect at the frame end, idle at inactive levels
        push_idle(6, "R8 R5 idle");

        repeat (58) @(negedge clk);
        wr(ADDR_HTIME, 32'h0003_0008);
        wr(ADDR_SKEW, 32'd8);
        wr(ADDR_COLOR, 32'h0022_0011);
        wr(ADDR_POL, 32'd3);
        repeat (80) @(negedge clk);
        wr(ADDR_RUN, 32'd0);
        drain();

        // R9: frame counter disabled holds, line counter keeps running
        wr(ADDR_CNTEN, 32'd2);
        m_fen = 0;
        wr(ADDR_RUN, 32'd1);
        #1;
        push_frame(1'b1, "R9 R8 frame5");
        push_idle(4, "R9 R8 idle2");
        repeat (20) @(negedge clk);
        wr(ADDR_RUN, 32'd0);
        drain();
        check1("R9 frame_cnt final", 32'(frame_cnt), 32'd4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule